// File: doc/BRIEF.md
# Clock Control Register Bank with Write Password

This block is the software-facing register bank of a clock generator. It holds 32-bit control words for a set of PLLs, their analog settings, a few plain channel words and a bank of clock dividers, each divider owning a control word and a ratio word. The bus is a plain valid / write-enable / byte-address / data interface that accepts only whole, aligned 32-bit words. Reads return data in the same cycle as the request.

Every write must carry a fixed key in its top byte, or the bank ignores it. On an accepted write the key byte is zeroed before the word is stored. Word 0 is not stored at all. It is a live lock-status view, computed on every read from each PLL's analog-reset bit and power-down bit. One cycle after each accepted write, a one-cycle strobe names the word that changed. It also gives a class code and a unit number, so the clock datapath knows which PLL, or which PLL together with its channels, or which divider it must re-evaluate.

Top module: `clkctl_regbank`

## Requirements
- R1: A write whose bits [31:24] differ from 0x5A changes no stored word and raises no update strobe.
- R2: An accepted write stores bits [23:0] of the data with bits [31:24] forced to zero.
- R3: An access takes effect only when `bus_size` is 2'b10 (one word) and `bus_addr[1:0]` is 0. The word index is `bus_addr[6:2]`. Any other access leaves the state unchanged, raises no strobe, and reads as 0.
- R4: Reading index 0 returns, for PLL i (0..4), bit 4+i set exactly when bit 8 (analog reset) of index 1+i and bit 16 (power-down) of index 6+i are both clear. All other bits read 0. Writes to index 0 are discarded with no strobe.
- R5: A word read from any index other than 0 returns the value last stored there.
- R6: After reset, indices 1..5 hold 0x00000100, indices 6..10 hold 0x00010000 and all other indices hold 0. The lock view therefore reads 0.
- R7: In the cycle after an accepted write, `upd_valid` is high for exactly that cycle and `upd_idx` is the written index. Indices 1..5 give `upd_kind` 1 (PLL plus all its channels) with `upd_unit` = index-1.
- R8: Indices 6..10 give `upd_kind` 2 (PLL only) with `upd_unit` = index-6.
- R9: Indices 16..31 give `upd_kind` 3 (divider) with `upd_unit` = (index-16)/2. The control word is at the even index and the ratio word at the odd index above it.
- R10: Indices 11..15 give `upd_kind` 0 with `upd_unit` 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_valid | input | 1 | Access request this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 7 | Byte address |
| bus_size | input | 2 | Access size code, 2'b10 = 32-bit word |
| bus_wdata | input | 32 | Write data, key in [31:24] |
| bus_rdata | output | 32 | Read data, same cycle |
| upd_valid | output | 1 | One-cycle change strobe |
| upd_idx | output | 5 | Index of the changed word |
| upd_kind | output | 2 | Class of the changed word |
| upd_unit | output | 3 | PLL or divider number |

## Verification
A write and a lock-view read can overlap: the strobe for a write to a PLL word is still high in the very next cycle, when a read of index 0 may already be asking for the lock bits that the write just changed. The bench provokes this by clearing a PLL's power-down bit and reading index 0 straight away. In that one cycle it requires the strobe with the right class and unit and also the new lock bit. Random traffic mixes wrong keys, odd sizes and unaligned addresses, and each access is judged against a bench model of the word array.

// File: rtl/clkctl_pkg.sv
// Shared constants and types of the clock control register bank.
// Assumes 32-bit data words; the key byte sits in the top byte of every write.
package clkctl_pkg;
    localparam logic [7:0] WR_KEY     = 8'h5A;
    localparam logic [1:0] SIZE_WORD  = 2'b10;
    localparam int         ANARST_BIT = 8;
    localparam int         PWRDN_BIT  = 16;
    localparam int         LOCK_LSB   = 4;

    typedef enum logic [1:0] {
        KIND_PLAIN  = 2'd0,
        KIND_PLLGRP = 2'd1,
        KIND_PLLANA = 2'd2,
        KIND_DIV    = 2'd3
    } upd_kind_e;
endpackage

// File: rtl/clkctl_gate.sv
// Access qualifier: decides whether the current bus request is a legal word
// access and whether a write may be committed (key present, not the lock view).
// Assumes the bus presents a whole request in one cycle.
module clkctl_gate #(
    parameter int ADDR_W   = 7,
    parameter int LOCK_IDX = 0,
    localparam int IDX_W   = ADDR_W - 2
) (
    input  logic              bus_valid,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [1:0]        bus_size,
    input  logic [31:0]       bus_wdata,
    output logic              access_ok,
    output logic              wr_en,
    output logic [IDX_W-1:0]  idx,
    output logic [31:0]       wr_data
);
    import clkctl_pkg::*;

    // Qualify size, alignment, key and target of the request.
    always_comb begin
        idx       = bus_addr[ADDR_W-1:2];
        access_ok = bus_valid && (bus_size == SIZE_WORD) && (bus_addr[1:0] == 2'b00);
        wr_en     = access_ok && bus_we && (bus_wdata[31:24] == WR_KEY)
                    && (idx != IDX_W'(LOCK_IDX));
        wr_data   = {8'h00, bus_wdata[23:0]};
    end
endmodule

// File: rtl/clkctl_decode.sv
// Index classifier: maps a word index to the class of clock element it
// controls and the number of that element. Assumes regions do not overlap.
module clkctl_decode #(
    parameter int IDX_W        = 5,
    parameter int UNIT_W       = 3,
    parameter int PLL_CTL_BASE = 1,
    parameter int PLL_ANA_BASE = 6,
    parameter int PLAIN_BASE   = 11,
    parameter int DIV_BASE     = 16
) (
    input  logic [IDX_W-1:0]     idx,
    output clkctl_pkg::upd_kind_e kind,
    output logic [UNIT_W-1:0]    unit
);
    import clkctl_pkg::*;

    // Region lookup with unit offset inside the region.
    always_comb begin
        int i;
        i    = int'(idx);
        kind = KIND_PLAIN;
        unit = '0;
        if (i >= DIV_BASE) begin
            kind = KIND_DIV;
            unit = UNIT_W'((i - DIV_BASE) / 2);
        end else if (i >= PLAIN_BASE) begin
            kind = KIND_PLAIN;
        end else if (i >= PLL_ANA_BASE) begin
            kind = KIND_PLLANA;
            unit = UNIT_W'(i - PLL_ANA_BASE);
        end else if (i >= PLL_CTL_BASE) begin
            kind = KIND_PLLGRP;
            unit = UNIT_W'(i - PLL_CTL_BASE);
        end
    end
endmodule

// File: rtl/clkctl_store.sv
// Word storage: holds every control word, loads per-word defaults on reset and
// takes one qualified write per cycle. Assumes wr_data already has the key removed.
module clkctl_store #(
    parameter int NUM_REGS     = 32,
    parameter int IDX_W        = 5,
    parameter int NUM_PLL      = 5,
    parameter int PLL_CTL_BASE = 1,
    parameter int PLL_ANA_BASE = 6
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr_en,
    input  logic [IDX_W-1:0]          wr_idx,
    input  logic [31:0]               wr_data,
    output logic [NUM_REGS-1:0][31:0] regs_q
);
    import clkctl_pkg::*;

    function automatic logic [31:0] dflt(input int r);
        logic [31:0] v;
        v = '0;
        if (r >= PLL_CTL_BASE && r < PLL_CTL_BASE + NUM_PLL) v[ANARST_BIT] = 1'b1;
        if (r >= PLL_ANA_BASE && r < PLL_ANA_BASE + NUM_PLL) v[PWRDN_BIT] = 1'b1;
        return v;
    endfunction

    // Reset loads defaults; otherwise commit the qualified write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int r = 0; r < NUM_REGS; r++) regs_q[r] <= dflt(r);
        end else if (wr_en) begin
            regs_q[wr_idx] <= wr_data;
        end
    end

    AST_HOLD_ON_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(regs_q)); // R1
    AST_KEY_STRIPPED: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> regs_q[$past(wr_idx)][31:24] == 8'h00); // R2
    AST_RESET_DEFAULTS: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> regs_q[PLL_CTL_BASE][ANARST_BIT] && regs_q[PLL_ANA_BASE][PWRDN_BIT]); // R6
endmodule

// File: rtl/clkctl_lock.sv
// Live lock view: one bit per PLL, set when neither analog reset nor
// power-down is requested. Assumes NUM_PLL + LOCK_LSB fits in 32 bits.
module clkctl_lock #(
    parameter int NUM_PLL = 5
) (
    input  logic [NUM_PLL-1:0][31:0] pll_ctl,
    input  logic [NUM_PLL-1:0][31:0] pll_ana,
    output logic [31:0]              lock_word
);
    import clkctl_pkg::*;

    logic [NUM_PLL-1:0] locked;

    for (genvar g = 0; g < NUM_PLL; g++) begin : g_pll
        // One PLL counts as locked when both hold-off bits are clear.
        assign locked[g] = !pll_ctl[g][ANARST_BIT] && !pll_ana[g][PWRDN_BIT];
    end

    // Place the per-PLL bits at their fixed position.
    always_comb begin
        lock_word = '0;
        lock_word[LOCK_LSB +: NUM_PLL] = locked;
    end
endmodule

// File: rtl/clkctl_regbank.sv
// Top of the clock control register bank: key-protected writes, same-cycle
// reads with a live lock view at index 0, and a registered one-cycle change
// strobe classifying the written word. Assumes one bus request per cycle.
module clkctl_regbank #(
    parameter int ADDR_W  = 7,
    parameter int NUM_PLL = 5,
    parameter int NUM_DIV = 8,
    localparam int IDX_W        = ADDR_W - 2,
    localparam int NUM_REGS     = 1 << IDX_W,
    localparam int MAX_UNITS    = (NUM_PLL > NUM_DIV) ? NUM_PLL : NUM_DIV,
    localparam int UNIT_W       = (MAX_UNITS > 1) ? $clog2(MAX_UNITS) : 1,
    localparam int LOCK_IDX     = 0,
    localparam int PLL_CTL_BASE = 1,
    localparam int PLL_ANA_BASE = PLL_CTL_BASE + NUM_PLL,
    localparam int PLAIN_BASE   = PLL_ANA_BASE + NUM_PLL,
    localparam int DIV_BASE     = NUM_REGS - 2 * NUM_DIV
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_valid,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [1:0]        bus_size,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              upd_valid,
    output logic [IDX_W-1:0]  upd_idx,
    output logic [1:0]        upd_kind,
    output logic [UNIT_W-1:0] upd_unit
);
    import clkctl_pkg::*;

    logic                      access_ok, wr_en;
    logic [IDX_W-1:0]          idx;
    logic [31:0]               wr_data, lock_word;
    logic [NUM_REGS-1:0][31:0] regs_q;
    logic [NUM_PLL-1:0][31:0]  pll_ctl, pll_ana;
    upd_kind_e                 dec_kind;
    logic [UNIT_W-1:0]         dec_unit;

    clkctl_gate #(.ADDR_W(ADDR_W), .LOCK_IDX(LOCK_IDX)) u_gate (
        .bus_valid(bus_valid), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_size(bus_size), .bus_wdata(bus_wdata), .access_ok(access_ok),
        .wr_en(wr_en), .idx(idx), .wr_data(wr_data)
    );

    clkctl_decode #(.IDX_W(IDX_W), .UNIT_W(UNIT_W), .PLL_CTL_BASE(PLL_CTL_BASE),
        .PLL_ANA_BASE(PLL_ANA_BASE), .PLAIN_BASE(PLAIN_BASE), .DIV_BASE(DIV_BASE)) u_dec (
        .idx(idx), .kind(dec_kind), .unit(dec_unit)
    );

    clkctl_store #(.NUM_REGS(NUM_REGS), .IDX_W(IDX_W), .NUM_PLL(NUM_PLL),
        .PLL_CTL_BASE(PLL_CTL_BASE), .PLL_ANA_BASE(PLL_ANA_BASE)) u_store (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(idx),
        .wr_data(wr_data), .regs_q(regs_q)
    );

    for (genvar g = 0; g < NUM_PLL; g++) begin : g_pllw
        // Route each PLL's two words to the lock view.
        assign pll_ctl[g] = regs_q[PLL_CTL_BASE + g];
        assign pll_ana[g] = regs_q[PLL_ANA_BASE + g];
    end

    clkctl_lock #(.NUM_PLL(NUM_PLL)) u_lock (
        .pll_ctl(pll_ctl), .pll_ana(pll_ana), .lock_word(lock_word)
    );

    // Same-cycle read: lock view at its index, stored word elsewhere, 0 if illegal.
    always_comb begin
        bus_rdata = '0;
        if (access_ok && !bus_we)
            bus_rdata = (idx == IDX_W'(LOCK_IDX)) ? lock_word : regs_q[idx];
    end

    // Registered change strobe with index, class and unit of the committed write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            upd_valid <= 1'b0;
            upd_idx   <= '0;
            upd_kind  <= KIND_PLAIN;
            upd_unit  <= '0;
        end else begin
            upd_valid <= wr_en;
            if (wr_en) begin
                upd_idx  <= idx;
                upd_kind <= dec_kind;
                upd_unit <= dec_unit;
            end
        end
    end

    AST_BAD_KEY_NO_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        bus_valid && bus_we && bus_wdata[31:24] != WR_KEY |=> !upd_valid); // R1
    AST_UNALIGNED_NO_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        bus_valid && bus_addr[1:0] != 2'b00 |=> !upd_valid); // R3
    AST_STROBE_TRACKS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $past(wr_en) |-> upd_valid && upd_idx == $past(idx)); // R7
    AST_STROBE_ONLY_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && !$past(wr_en) |-> !upd_valid); // R7
    AST_GRP_UNIT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        upd_valid && upd_kind == KIND_PLLGRP |-> int'(upd_unit) < NUM_PLL); // R7
    AST_DIV_REGION: assert property (@(posedge clk) disable iff (!rst_n)
        upd_valid && upd_kind == KIND_DIV |-> int'(upd_idx) >= DIV_BASE); // R9
    AST_LOCK_CLEAR_AFTER_RESET: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> lock_word == 32'h0); // R6
endmodule

// File: tb/sim_clkctl_regbank.sv
module sim_clkctl_regbank;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        bus_valid, bus_we;
    logic [6:0]  bus_addr;
    logic [1:0]  bus_size;
    logic [31:0] bus_wdata, bus_rdata;
    logic        upd_valid;
    logic [4:0]  upd_idx;
    logic [1:0]  upd_kind;
    logic [2:0]  upd_unit;

    logic [31:0] exp_mem [32];
    int n_chk = 0;
    int n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    clkctl_regbank u0 (
        .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_size(bus_size), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .upd_valid(upd_valid), .upd_idx(upd_idx),
        .upd_kind(upd_kind), .upd_unit(upd_unit)
    );

    function automatic logic [31:0] exp_default(input int r);
        if (r >= 1 && r <= 5) return 32'h0000_0100;
        if (r >= 6 && r <= 10) return 32'h0001_0000;
        return 32'h0;
    endfunction

    function automatic logic [31:0] exp_lock();
        logic [31:0] v = '0;
        for (int i = 0; i < 5; i++)
            v[4+i] = !exp_mem[1+i][8] && !exp_mem[6+i][16];
        return v;
    endfunction

    function automatic logic [1:0] exp_kind(input int r);
        if (r >= 16) return 2'd3;
        if (r >= 11) return 2'd0;
        if (r >= 6) return 2'd2;
        return 2'd1;
    endfunction

    function automatic logic [2:0] exp_unit(input int r);
        if (r >= 16) return 3'((r - 16) / 2);
        if (r >= 11) return 3'd0;
        if (r >= 6) return 3'(r - 6);
        return 3'(r - 1);
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Write, then at the next negedge check the strobe and update the model.
    task automatic wr(input logic [6:0] a, input logic [1:0] sz, input logic [31:0] d, input string req);
        bit acc;
        int r;
        r = int'(a[6:2]);
        acc = (sz == 2'b10) && (a[1:0] == 2'b00) && (d[31:24] == 8'h5A) && (r != 0);
        bus_valid = 1'b1; bus_we = 1'b1; bus_addr = a; bus_size = sz; bus_wdata = d;
        @(posedge clk);
        @(negedge clk);
        bus_valid = 1'b0; bus_we = 1'b0;
        chk(upd_valid == acc, {req, " strobe"}, 32'(upd_valid), 32'(acc));
        if (acc) begin
            chk(upd_idx == r[4:0], {req, " R7 idx"}, 32'(upd_idx), 32'(r));
            chk(upd_kind == exp_kind(r), {req, " R8 R9 R10 kind"}, 32'(upd_kind), 32'(exp_kind(r)));
            chk(upd_unit == exp_unit(r), {req, " unit"}, 32'(upd_unit), 32'(exp_unit(r)));
            exp_mem[r] = {8'h00, d[23:0]};
        end
    endtask

    // Same-cycle read check, held until the next negedge.
    task automatic rd(input logic [6:0] a, input logic [1:0] sz, input string req);
        logic [31:0] e;
        int r;
        r = int'(a[6:2]);
        if (sz != 2'b10 || a[1:0] != 2'b00) e = 32'h0;
        else if (r == 0) e = exp_lock();
        else e = exp_mem[r];
        bus_valid = 1'b1; bus_we = 1'b0; bus_addr = a; bus_size = sz;
        #1;
        chk(bus_rdata == e, req, bus_rdata, e);
        @(negedge clk);
        bus_valid = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        void'($urandom(32'd2024));
        rst_n = 1'b0; bus_valid = 1'b0; bus_we = 1'b0;
        bus_addr = '0; bus_size = 2'b10; bus_wdata = '0;
        for (int r = 0; r < 32; r++) exp_mem[r] = exp_default(r);
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        chk(upd_valid == 1'b0, "R6 R7 no strobe after reset", 32'(upd_valid), 32'h0);
        for (int r = 0; r < 32; r++) rd(7'(r * 4), 2'b10, "R6 R5 reset value");

        // R1: wrong key leaves word and strobe untouched.
        wr(7'(12 * 4), 2'b10, 32'hA5_123456, "R1 bad key");
        rd(7'(12 * 4), 2'b10, "R1 word unchanged");
        // R2: key byte stripped.
        wr(7'(13 * 4), 2'b10, 32'h5A_ABCDEF, "R2 accepted");
        rd(7'(13 * 4), 2'b10, "R2 key cleared");
        // R3: misaligned and short accesses.
        wr(7'(13 * 4 + 1), 2'b10, 32'h5A_000001, "R3 unaligned write");
        rd(7'(13 * 4), 2'b10, "R3 word kept");
        rd(7'(13 * 4 + 2), 2'b10, "R3 unaligned read zero");
        rd(7'(13 * 4), 2'b01, "R3 short read zero");
        wr(7'(14 * 4), 2'b00, 32'h5A_000077, "R3 byte write");
        rd(7'(14 * 4), 2'b10, "R3 byte write ignored");
        // R4: writes to the lock view are discarded.
        wr(7'h00, 2'b10, 32'h5A_FFFFFF, "R4 lock write");
        rd(7'h00, 2'b10, "R4 lock still zero");
        // R4/R7: release PLL 2 in two steps; lock read overlaps the strobe.
        wr(7'(3 * 4), 2'b10, 32'h5A_000000, "R7 pll group write");
        rd(7'h00, 2'b10, "R4 power-down still holds lock");
        wr(7'(8 * 4), 2'b10, 32'h5A_000000, "R8 pll analog write");
        chk(upd_valid && upd_kind == 2'd2 && upd_unit == 3'd2, "R8 overlap strobe",
            {29'h0, upd_unit}, 32'd2);
        rd(7'h00, 2'b10, "R4 lock bit in strobe cycle");
        chk(upd_valid == 1'b0, "R7 strobe lasts one cycle", 32'(upd_valid), 32'h0);
        wr(7'(3 * 4), 2'b10, 32'h5A_000100, "R7 analog reset again");
        rd(7'h00, 2'b10, "R4 lock cleared by analog reset");
        // R9: divider edges.
        wr(7'(17 * 4), 2'b10, 32'h5A_003000, "R9 first divider ratio");
        wr(7'(30 * 4), 2'b10, 32'h5A_000011, "R9 last divider control");
        wr(7'(31 * 4), 2'b10, 32'h5A_004800, "R9 last divider ratio");
        wr(7'(11 * 4), 2'b10, 32'h5A_000042, "R10 plain word");

        // Random mix of traffic.
        for (int k = 0; k < 400; k++) begin
            logic [6:0] a;
            logic [1:0] sz;
            logic [31:0] d;
            a = 7'(($urandom % 32) * 4);
            if ($urandom % 10 == 0) a[1:0] = 2'($urandom % 4);
            sz = ($urandom % 10 == 0) ? 2'($urandom % 4) : 2'b10;
            d = $urandom;
            if ($urandom % 5 != 0) d[31:24] = 8'h5A;
            wr(a, sz, d, "R1 R2 R3 random write");
            rd(7'(($urandom % 32) * 4), 2'b10, "R4 R5 random read");
        end

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule